// File: doc/BRIEF.md
# Debug Opcode Injection Sequencer

This block sits between a debug host's command port and the emulation interface of a small stack processor. It turns each host command into an ordered stream of single 8-bit opcodes and feeds them to the halted core one at a time. Every debug access is built only from stack-machine instructions. The two memory accesses must return the core's stack pointer to the value it held before the access.

After reset the block raises the emulation request. It issues nothing until the core reports both ready and break. Each opcode is placed on the instruction bus one cycle before a one-cycle execute strobe. The next opcode waits until the core shows ready again. A watchdog gives up on a core that never becomes ready again. For memory accesses, the block records the stack pointer after the opening push of the stack pointer and checks it again after the closing NOP. Any difference sets a sticky error flag.

Top module: `dis_seq`

## Requirements
- R1: While reset is low, `emu_req`, `emu_exec`, `cmd_ready` and `done` are 0 and `emu_ir` is the NOP value 0x0B. After reset is released, `emu_req` is 1 from the first clock edge onward and then stays 1.
- R2: Every opcode appears on `emu_ir` at least one cycle before `emu_exec` goes high. `emu_exec` is high for exactly one cycle, and `emu_ir` does not change during that cycle.
- R3: After an execute strobe, no further opcode is strobed until `emu_rdy` has been seen high. `emu_rdy` is first looked at in the second cycle after the strobe.
- R4: A 32-bit word W is pushed as five opcodes, in this order: 0x80|W[31:28], then 0x80|W[27:21], 0x80|W[20:14], 0x80|W[13:7] and 0x80|W[6:0].
- R5: Command code 0 (read stack pointer) injects 0x02, 0x0B, 0x0D. `rdata` is set to `dbg_tos` as it stands when the 0x0B completes.
- R6: Command code 1 (read memory) injects 0x02, then the push of `cmd_addr`, then 0x08, 0x0B, 0x71, 0x0D, 0x0B. `rdata` is set to `dbg_tos` as it stands when the first 0x0B completes.
- R7: Command code 2 (write memory) injects 0x02, the push of `cmd_data`, 0x0B, the push of `cmd_addr`, 0x0C, 0x70, 0x0D, 0x0B.
- R8: For codes 1 and 2, `dbg_sp` is sampled when the first opcode completes and compared when the last opcode completes. A mismatch sets `sp_err`, which stays set until reset.
- R9: Command code 3 (set program counter) injects the push of `cmd_addr`, then 0x04. Command code 4 (leave or step) injects only 0x00.
- R10: No opcode is strobed and `cmd_ready` stays 0 until `emu_rdy` and `core_brk` have both been seen high in the same cycle.
- R11: `cmd_ready` is high only while the block is idle. Each accepted command ends with a one-cycle `done` pulse. Codes 5 to 7 end with `done` and inject nothing.
- R12: If `emu_rdy` is still low WDOG_CYCLES cycles after a strobe, the command is abandoned. `done` pulses one cycle later and `timeout` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_code | input | 3 | Command code |
| cmd_addr | input | 32 | Memory address or program counter target |
| cmd_data | input | 32 | Word to write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Captured top-of-stack from the last read |
| sp_err | output | 1 | Sticky stack-pointer mismatch |
| timeout | output | 1 | Sticky watchdog expiry |
| emu_req | output | 1 | Emulation request to the core |
| emu_ir | output | 8 | Injected opcode |
| emu_exec | output | 1 | One-cycle execute strobe |
| emu_rdy | input | 1 | Core ready for the next opcode |
| core_brk | input | 1 | Core is halted at a break |
| dbg_tos | input | 32 | Core top-of-stack debug value |
| dbg_sp | input | 32 | Core stack-pointer debug value |

## Verification
Each command code is sent with addresses and data whose five immediate chunks differ. An all-ones address shows that the first chunk is masked to four bits. The write uses different data and address words, so swapped or misordered pushes are caught. The core model varies its ready latency from one to four cycles, which tells a block that waits for ready apart from one that counts a fixed delay. A stack-pointer disturbance in the middle of a read separates a real comparison from a flag that never moves. A core that never becomes ready again checks the exact watchdog delay.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int WORD_W   = 32;
  localparam int OP_W     = 8;
  localparam int IMM_BITS = 7;
  localparam int IMM_N    = (WORD_W + IMM_BITS - 1) / IMM_BITS;
  localparam int IDX_W    = 5;

  typedef enum logic [2:0] {
    CMD_RDSP  = 3'd0,
    CMD_RDMEM = 3'd1,
    CMD_WRMEM = 3'd2,
    CMD_SETPC = 3'd3,
    CMD_LEAVE = 3'd4,
    CMD_RSV5  = 3'd5,
    CMD_RSV6  = 3'd6,
    CMD_RSV7  = 3'd7
  } dcmd_e;

  typedef struct packed {
    logic [OP_W-1:0] op;
    logic            last;
    logic            cap;
    logic            smp;
    logic            chk;
  } step_t;

  // k-th immediate slice of a word, most significant slice first
  function automatic logic [IMM_BITS-1:0] imm_chunk(input logic [WORD_W-1:0] w, input int k);
    logic [WORD_W-1:0] s;
    s = w >> (IMM_BITS * (IMM_N - 1 - k));
    return s[IMM_BITS-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] seq_len(input dcmd_e c);
    case (c)
      CMD_RDSP:  return IDX_W'(3);
      CMD_RDMEM: return IDX_W'(IMM_N + 6);
      CMD_WRMEM: return IDX_W'(2 * IMM_N + 6);
      CMD_SETPC: return IDX_W'(IMM_N + 1);
      CMD_LEAVE: return IDX_W'(1);
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/dis_opgen.sv
module dis_opgen
  import dis_pkg::*;
#(
  parameter logic [7:0] OP_NOP    = 8'h0B,
  parameter logic [7:0] OP_IMM    = 8'h80,
  parameter logic [7:0] OP_LOADSP = 8'h60,
  parameter logic [7:0] OP_PUSHSP = 8'h02,
  parameter logic [7:0] OP_POPPC  = 8'h04,
  parameter logic [7:0] OP_LOAD   = 8'h08,
  parameter logic [7:0] OP_STORE  = 8'h0C,
  parameter logic [7:0] OP_POPSP  = 8'h0D,
  parameter logic [7:0] OP_BREAK  = 8'h00,
  parameter logic [4:0] LSP_RD    = 5'h11,
  parameter logic [4:0] LSP_WR    = 5'h10
) (
  input  dcmd_e              cmd,
  input  logic [IDX_W-1:0]   idx,
  input  logic [WORD_W-1:0]  addr,
  input  logic [WORD_W-1:0]  data,
  output step_t              step
);
  function automatic logic [OP_W-1:0] imm_op(input logic [WORD_W-1:0] w, input int k);
    return OP_IMM | {{(OP_W-IMM_BITS){1'b0}}, imm_chunk(w, k)};
  endfunction

  always_comb begin
    int i;
    i = int'(idx);
    step = '0;
    step.op = OP_NOP;
    case (cmd)
      CMD_RDSP: begin
        if (i == 0) step.op = OP_PUSHSP;
        else if (i == 1) step.cap = 1'b1;
        else begin step.op = OP_POPSP; step.last = 1'b1; end
      end
      CMD_RDMEM: begin
        if (i == 0) begin step.op = OP_PUSHSP; step.smp = 1'b1; end
        else if (i <= IMM_N) step.op = imm_op(addr, i - 1);
        else if (i == IMM_N + 1) step.op = OP_LOAD;
        else if (i == IMM_N + 2) step.cap = 1'b1;
        else if (i == IMM_N + 3) step.op = OP_LOADSP | {3'b000, LSP_RD};
        else if (i == IMM_N + 4) step.op = OP_POPSP;
        else begin step.last = 1'b1; step.chk = 1'b1; end
      end
      CMD_WRMEM: begin
        if (i == 0) begin step.op = OP_PUSHSP; step.smp = 1'b1; end
        else if (i <= IMM_N) step.op = imm_op(data, i - 1);
        else if (i == IMM_N + 1) step.op = OP_NOP;
        else if (i <= 2 * IMM_N + 1) step.op = imm_op(addr, i - IMM_N - 2);
        else if (i == 2 * IMM_N + 2) step.op = OP_STORE;
        else if (i == 2 * IMM_N + 3) step.op = OP_LOADSP | {3'b000, LSP_WR};
        else if (i == 2 * IMM_N + 4) step.op = OP_POPSP;
        else begin step.last = 1'b1; step.chk = 1'b1; end
      end
      CMD_SETPC: begin
        if (i < IMM_N) step.op = imm_op(addr, i);
        else begin step.op = OP_POPPC; step.last = 1'b1; end
      end
      CMD_LEAVE: begin
        step.op = OP_BREAK;
        step.last = 1'b1;
      end
      default: step.last = 1'b1;
    endcase
  end
endmodule

// File: rtl/dis_issue.sv
module dis_issue #(
  parameter int         OP_W        = 8,
  parameter int         WDOG_CYCLES = 1024,
  parameter logic [7:0] OP_IDLE     = 8'h0B
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OP_W-1:0] op,
  input  logic            emu_rdy,
  output logic [OP_W-1:0] emu_ir,
  output logic            emu_exec,
  output logic            fin,
  output logic            tmo
);
  localparam int CNT_W = $clog2(WDOG_CYCLES + 1) + 1;

  typedef enum logic [2:0] {I_IDLE, I_SHOW, I_FIRE, I_SETTLE, I_WAIT} ist_e;
  ist_e             st;
  logic [CNT_W-1:0] cnt;
  logic             wdog_hit;

  assign wdog_hit = (cnt >= CNT_W'(WDOG_CYCLES));
  assign emu_exec = (st == I_FIRE);
  assign fin      = (st == I_WAIT) && emu_rdy;
  assign tmo      = (st == I_WAIT) && !emu_rdy && wdog_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= I_IDLE;
      emu_ir <= OP_W'(OP_IDLE);
      cnt    <= '0;
    end else begin
      case (st)
        I_IDLE:   if (start) begin emu_ir <= op; st <= I_SHOW; end
        I_SHOW:   st <= I_FIRE;
        I_FIRE:   begin st <= I_SETTLE; cnt <= CNT_W'(1); end
        I_SETTLE: begin st <= I_WAIT; cnt <= cnt + 1'b1; end
        I_WAIT: begin
          if (emu_rdy || wdog_hit) begin
            st     <= I_IDLE;
            emu_ir <= OP_W'(OP_IDLE);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= I_IDLE;
      endcase
    end
  end

  AST_EXEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    emu_exec |=> !emu_exec); // R2
  AST_IR_HELD_AT_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    emu_exec |-> $stable(emu_ir)); // R2
  AST_NO_RESTRIKE: assert property (@(posedge clk) disable iff (!rst_n)
    emu_exec |=> !start); // R3
endmodule

// File: rtl/dis_spcheck.sv
module dis_spcheck #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp,
  input  logic         chk,
  input  logic [W-1:0] sp_in,
  output logic         err
);
  logic [W-1:0] sp_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_ref <= '0;
      err    <= 1'b0;
    end else begin
      if (smp) sp_ref <= sp_in;
      if (chk && (sp_in != sp_ref)) err <= 1'b1;
    end
  end

  AST_SPERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8
endmodule

// File: rtl/dis_seq.sv
module dis_seq
  import dis_pkg::*;
#(
  parameter int         WDOG_CYCLES = 1024,
  parameter logic [7:0] OP_NOP      = 8'h0B,
  parameter logic [7:0] OP_IMM      = 8'h80,
  parameter logic [7:0] OP_LOADSP   = 8'h60,
  parameter logic [7:0] OP_PUSHSP   = 8'h02,
  parameter logic [7:0] OP_POPPC    = 8'h04,
  parameter logic [7:0] OP_LOAD     = 8'h08,
  parameter logic [7:0] OP_STORE    = 8'h0C,
  parameter logic [7:0] OP_POPSP    = 8'h0D,
  parameter logic [7:0] OP_BREAK    = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_code,
  input  logic [31:0] cmd_addr,
  input  logic [31:0] cmd_data,
  output logic        done,
  output logic [31:0] rdata,
  output logic        sp_err,
  output logic        timeout,
  output logic        emu_req,
  output logic [7:0]  emu_ir,
  output logic        emu_exec,
  input  logic        emu_rdy,
  input  logic        core_brk,
  input  logic [31:0] dbg_tos,
  input  logic [31:0] dbg_sp
);
  typedef enum logic [1:0] {T_HALT, T_IDLE, T_RUN} tst_e;
  tst_e              st;
  dcmd_e             cmd_q;
  logic [WORD_W-1:0] addr_q, data_q;
  logic [IDX_W-1:0]  idx;
  logic              kick;
  step_t             step;
  logic              fin, tmo;
  logic              sp_smp, sp_chk;
  dcmd_e             cmd_in;

  assign cmd_in    = dcmd_e'(cmd_code);
  assign cmd_ready = (st == T_IDLE);
  assign sp_smp    = (st == T_RUN) && fin && step.smp;
  assign sp_chk    = (st == T_RUN) && fin && step.chk;

  dis_opgen #(
    .OP_NOP(OP_NOP), .OP_IMM(OP_IMM), .OP_LOADSP(OP_LOADSP), .OP_PUSHSP(OP_PUSHSP),
    .OP_POPPC(OP_POPPC), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE), .OP_POPSP(OP_POPSP),
    .OP_BREAK(OP_BREAK), .LSP_RD(5'h11), .LSP_WR(5'h10)
  ) u_gen (
    .cmd(cmd_q), .idx(idx), .addr(addr_q), .data(data_q), .step(step)
  );

  dis_issue #(.OP_W(OP_W), .WDOG_CYCLES(WDOG_CYCLES), .OP_IDLE(OP_NOP)) u_iss (
    .clk(clk), .rst_n(rst_n), .start(kick), .op(step.op), .emu_rdy(emu_rdy),
    .emu_ir(emu_ir), .emu_exec(emu_exec), .fin(fin), .tmo(tmo)
  );

  dis_spcheck #(.W(WORD_W)) u_spc (
    .clk(clk), .rst_n(rst_n), .smp(sp_smp), .chk(sp_chk), .sp_in(dbg_sp), .err(sp_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= T_HALT;
      cmd_q   <= CMD_LEAVE;
      addr_q  <= '0;
      data_q  <= '0;
      idx     <= '0;
      kick    <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
      timeout <= 1'b0;
      emu_req <= 1'b0;
    end else begin
      kick <= 1'b0;
      done <= 1'b0;
      case (st)
        T_HALT: begin
          emu_req <= 1'b1;
          if (emu_req && emu_rdy && core_brk) st <= T_IDLE;
        end
        T_IDLE: begin
          if (cmd_valid) begin
            cmd_q  <= cmd_in;
            addr_q <= cmd_addr;
            data_q <= cmd_data;
            idx    <= '0;
            if (seq_len(cmd_in) == '0) begin
              done <= 1'b1;
            end else begin
              st   <= T_RUN;
              kick <= 1'b1;
            end
          end
        end
        T_RUN: begin
          if (tmo) begin
            timeout <= 1'b1;
            done    <= 1'b1;
            st      <= T_IDLE;
          end else if (fin) begin
            if (step.cap) rdata <= dbg_tos;
            if (step.last) begin
              done <= 1'b1;
              st   <= T_IDLE;
            end else begin
              idx  <= idx + 1'b1;
              kick <= 1'b1;
            end
          end
        end
        default: st <= T_HALT;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    emu_req |=> emu_req); // R1
  AST_NO_EXEC_IN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_HALT) |-> (!emu_exec && !cmd_ready)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> timeout); // R12
  AST_TMO_ENDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (done && timeout)); // R12
endmodule

// File: tb/sim_dis_seq.sv
module sim_dis_seq;
  localparam int WDOG = 40;
  localparam logic [31:0] TOS_BASE = 32'hC0DE_0000;

  typedef struct packed {
    logic [2:0]  c;
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{3'd0, 32'h0000_0000, 32'h0000_0000, 4'd1},
    '{3'd1, 32'h0000_08D8, 32'h0000_0000, 4'd2},
    '{3'd2, 32'h0000_08D8, 32'hDEAD_BEEF, 4'd1},
    '{3'd1, 32'hFFFF_FFFF, 32'h0000_0000, 4'd3},
    '{3'd2, 32'h8000_0001, 32'h1234_5678, 4'd4},
    '{3'd3, 32'h0000_0000, 32'h0000_0000, 4'd1},
    '{3'd3, 32'hA5A5_A5A5, 32'h0000_0000, 4'd2},
    '{3'd4, 32'h0000_0000, 32'h0000_0000, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = '0;
  logic [31:0] cmd_addr = '0, cmd_data = '0;
  logic cmd_ready, done, sp_err, timeout, emu_req, emu_exec;
  logic [31:0] rdata;
  logic [7:0] emu_ir;
  logic emu_rdy = 1'b0;
  logic core_brk = 1'b0;
  logic [31:0] dbg_tos = TOS_BASE;
  logic [31:0] dbg_sp = 32'h0000_7F00;

  logic model_on = 1'b0, stall = 1'b0, sp_bump = 1'b0;
  int cur_lat = 1;
  int wait_cnt = 0;
  int exec_n = 0, exec_any = 0, start_n = 0;
  int r2_viol = 0, r3_viol = 0;
  logic [7:0] log_q [0:255];
  logic [7:0] prev_ir = 8'h0B;
  logic prev_exec = 1'b0;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_q [0:31];
  int exp_n;

  always #5 clk = ~clk;

  dis_seq #(.WDOG_CYCLES(WDOG)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .done(done),
    .rdata(rdata), .sp_err(sp_err), .timeout(timeout), .emu_req(emu_req),
    .emu_ir(emu_ir), .emu_exec(emu_exec), .emu_rdy(emu_rdy), .core_brk(core_brk),
    .dbg_tos(dbg_tos), .dbg_sp(dbg_sp)
  );

  // core model, acting away from the active edge
  always @(negedge clk) begin
    if (emu_exec) exec_any++;
    if (emu_exec && (prev_exec || emu_ir != prev_ir)) r2_viol++;
    prev_exec = emu_exec;
    prev_ir   = emu_ir;
    if (!model_on) begin
      emu_rdy  = 1'b0;
      wait_cnt = 0;
    end else if (emu_exec) begin
      if (!emu_rdy) r3_viol++;
      log_q[exec_n[7:0]] = emu_ir;
      exec_n++;
      emu_rdy  = 1'b0;
      wait_cnt = cur_lat;
    end else if (!emu_rdy && !stall) begin
      if (wait_cnt <= 1) begin
        emu_rdy = 1'b1;
        dbg_tos = TOS_BASE + 32'(exec_n);
        if (sp_bump && exec_n == start_n + 3) dbg_sp = dbg_sp + 32'd4;
      end else begin
        wait_cnt--;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [7:0] op);
    exp_q[exp_n] = op;
    exp_n++;
  endtask

  task automatic push_word(input logic [31:0] w);  // R4 slicing
    push_exp({4'h8, w[31:28]});
    push_exp({1'b1, w[27:21]});
    push_exp({1'b1, w[20:14]});
    push_exp({1'b1, w[13:7]});
    push_exp({1'b1, w[6:0]});
  endtask

  task automatic build_exp(input logic [2:0] c, input logic [31:0] a, input logic [31:0] d);
    exp_n = 0;
    case (c)
      3'd0: begin push_exp(8'h02); push_exp(8'h0B); push_exp(8'h0D); end
      3'd1: begin
        push_exp(8'h02); push_word(a); push_exp(8'h08); push_exp(8'h0B);
        push_exp(8'h71); push_exp(8'h0D); push_exp(8'h0B);
      end
      3'd2: begin
        push_exp(8'h02); push_word(d); push_exp(8'h0B); push_word(a);
        push_exp(8'h0C); push_exp(8'h70); push_exp(8'h0D); push_exp(8'h0B);
      end
      3'd3: begin push_word(a); push_exp(8'h04); end
      3'd4: push_exp(8'h00);
      default: ;
    endcase
  endtask

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0: return "R5";
      3'd1: return "R6 R4";
      3'd2: return "R7 R4";
      3'd3: return "R9 R4";
      3'd4: return "R9";
      default: return "R11";
    endcase
  endfunction

  // sends one command, returns after the done pulse; busy = cmd_ready right after acceptance
  task automatic send(input logic [2:0] c, input logic [31:0] a, input logic [31:0] d,
                      output logic busy_rdy, output int n_wait);
    @(negedge clk);
    start_n   = exec_n;
    cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_rdy  = cmd_ready;
    n_wait    = 0;
    while (!done && n_wait < 5000) begin
      @(negedge clk);
      n_wait++;
    end
  endtask

  task automatic check_seq(input logic [2:0] c);
    int bad;
    bad = 0;
    if (exec_n - start_n != exp_n) bad = 1;
    for (int k = 0; k < exp_n && bad == 0; k++)
      if (log_q[(start_n + k) % 256] !== exp_q[k]) bad = k + 2;
    n_chk++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s opcode stream: actual count %0d expected %0d, first bad index %0d",
               req_of(c), exec_n - start_n, exp_n, bad - 2);
    end
  endtask

  initial begin
    logic b;
    int w, t0;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 emu_req in reset", 32'(emu_req), 32'd0);
    check("R1 emu_ir in reset", 32'(emu_ir), 32'h0B);
    check("R1 exec/ready/done in reset", {29'd0, emu_exec, cmd_ready, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 emu_req after reset", 32'(emu_req), 32'd1);
    // R10 no injection before the core is halted
    repeat (10) @(negedge clk);
    check("R10 cmd_ready with core running", 32'(cmd_ready), 32'd0);
    model_on = 1'b1;
    repeat (10) @(negedge clk);
    check("R10 cmd_ready with ready but no break", 32'(cmd_ready), 32'd0);
    check("R10 no strobe before halt", 32'(exec_any), 32'd0);
    core_brk = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 cmd_ready after halt", 32'(cmd_ready), 32'd1);

    // table of commands
    for (int v = 0; v < 8; v++) begin
      cur_lat = int'(VEC[v].lat);
      build_exp(VEC[v].c, VEC[v].a, VEC[v].d);
      send(VEC[v].c, VEC[v].a, VEC[v].d, b, w);
      check("R11 busy blocks commands", 32'(b), 32'd0);
      check("R11 done seen", 32'(done), 32'd1);
      check_seq(VEC[v].c);
      if (VEC[v].c == 3'd0) check("R5 rdata", rdata, TOS_BASE + 32'(start_n + 2));
      if (VEC[v].c == 3'd1) check("R6 rdata", rdata, TOS_BASE + 32'(start_n + 8));
      if (VEC[v].c == 3'd1 || VEC[v].c == 3'd2) check("R8 no mismatch", 32'(sp_err), 32'd0);
      @(negedge clk);
      check("R11 done is one cycle", 32'(done), 32'd0);
    end

    // R11 reserved code completes with no opcode
    send(3'd6, 32'h1, 32'h2, b, w);
    check("R11 reserved done", 32'(done), 32'd1);
    check("R11 reserved injects nothing", 32'(exec_n - start_n), 32'd0);

    // R8 stack pointer disturbed mid-read
    sp_bump = 1'b1; cur_lat = 2;
    send(3'd1, 32'h0000_0100, 32'h0, b, w);
    check("R8 mismatch flagged", 32'(sp_err), 32'd1);
    sp_bump = 1'b0;
    send(3'd0, 32'h0, 32'h0, b, w);
    check("R8 mismatch sticky", 32'(sp_err), 32'd1);
    check("R5 rdata after error", rdata, TOS_BASE + 32'(start_n + 2));

    // R2 / R3 collected over the whole run
    check("R2 strobe shape", 32'(r2_viol), 32'd0);
    check("R3 strobe only when ready", 32'(r3_viol), 32'd0);

    // R12 core never ready again
    stall = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 3'd4;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!emu_exec) @(negedge clk);
    t0 = cyc;
    w = 0;
    while (!done && w < 1000) begin @(negedge clk); w++; end
    check("R12 done delay after strobe", 32'(cyc - t0), 32'(WDOG + 1));
    check("R12 timeout flag", 32'(timeout), 32'd1);
    repeat (3) @(negedge clk);
    check("R12 timeout sticky", 32'(timeout), 32'd1);

    summary();
    $finish;
  end
endmodule